// File: doc/BRIEF.md
# Ramp-Histogram Converter Linearity Analyzer

This block measures the static linearity of an analogue-to-digital converter while a slow linear ramp sweeps its input. During a capture window it counts how often each output code arrives. When the window closes it works through the inner codes one at a time with a sequential divider. For each inner code it derives the code width relative to the mean hit count, the differential non-linearity, and the integral non-linearity as a running sum. It keeps the worst absolute value of each.

A test controller pulses `start`, streams converter codes with `codeValid`, and pulses `stop`. It then waits for the one-cycle `done` pulse and reads the two worst-case figures. It can also read per-code values through a small read port. All results are signed fixed point in LSB units with `FRAC` fractional bits, so 1.0 LSB reads as 256 by default. For a production-style figure, the capture should hold about 16 to 32 samples per code. The two end codes are saturated by an overdriving ramp, so they take no part in the analysis.

Top module: `adc_histo_lin`

## Requirements
- R1: While capturing (after `start`, before `stop`), every cycle with `codeValid` high adds one hit to the counter of `code`. A sample presented in the `stop` cycle, or at any time outside the capture window, is ignored.
- R2: `start` clears all hit counters, the total, the per-code results, both worst-case outputs, `errFlag` and `ovfFlag`, and opens a new capture window.
- R3: A hit counter at its all-ones value stays there instead of wrapping, and `ovfFlag` goes high and stays high until the next `start`.
- R4: Codes 0 and 2^CODE_W−1 are left out of the total and out of every result; the read port returns 0 for both of them.
- R5: For each inner code i, width C(i) = floor(H(i)·(2^CODE_W−2)·2^FRAC / T), where T is the sum of hits over the inner codes. The code's DNL = C(i) − 2^FRAC, and `rdDnl` returns it as RES_W-bit two's complement.
- R6: INL of inner code i is the sum of DNL over codes 1..i, and `rdInl` returns it as RES_W-bit two's complement.
- R7: `dnlMax` and `inlMax` hold the largest absolute DNL and INL over the inner codes, as unsigned magnitudes in the same fixed-point scale.
- R8: After `stop`, `done` is high for exactly one cycle, once the last inner code (2^CODE_W−2) has been processed.
- R9: If T is zero at `stop`, no division takes place. `errFlag` is raised, all results stay zero, and `done` still pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears state and opens a capture window |
| stop | input | 1 | Closes the window and begins the analysis |
| codeValid | input | 1 | Qualifies `code` |
| code | input | CODE_W | Converter output code |
| rdAddr | input | CODE_W | Code selected on the read port |
| done | output | 1 | One-cycle pulse when the analysis ends |
| errFlag | output | 1 | Inner-code total was zero |
| ovfFlag | output | 1 | A hit counter saturated |
| dnlMax | output | RES_W | Worst absolute DNL, unsigned fixed point |
| inlMax | output | RES_W | Worst absolute INL, unsigned fixed point |
| rdDnl | output | RES_W | DNL of `rdAddr`, signed fixed point |
| rdInl | output | RES_W | INL of `rdAddr`, signed fixed point |

## Verification
Most internal faults surface only after `done`, because nothing leaves the block during capture. A miscounted or leaking histogram bin moves the width of that code, and through the shared total it moves the width of every code. The running sum then carries the error into the INL of every later code, so one bad bin shows up in many read-port values. A divider or accumulator fault shows up in the first code processed after it. Flag faults show up straight away: a dropped overflow flag or a doubled `done` pulse is visible within one cycle.

// File: rtl/adc_histo_pkg.sv
package adc_histo_pkg;
  typedef struct packed {
    logic clrAll;
    logic capEn;
    logic divLoad;
    logic commit;
    logic setErr;
  } histoCtl_t;
endpackage

// File: rtl/adc_histo_div.sv
module adc_histo_div #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             qDone
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem   <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      qDone <= 1'b0;
    end else begin
      qDone <= 1'b0;
      if (load) begin
        rem <= '0;
        quo <= num;
        cnt <= CNT_W'(NUM_W);
        run <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den}) begin
          rem <= DEN_W'(trial - {1'b0, den});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run   <= 1'b0;
          qDone <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_histo_dp.sv
module adc_histo_dp
  import adc_histo_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16,
  parameter int FRAC   = 8,
  localparam int RES_W = CODE_W + FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  histoCtl_t               ctl,
  input  logic [CODE_W-1:0]       idx,
  input  logic                    codeValid,
  input  logic [CODE_W-1:0]       code,
  input  logic [CODE_W-1:0]       rdAddr,
  output logic                    totalZero,
  output logic                    divDone,
  output logic                    errFlag,
  output logic                    ovfFlag,
  output logic [RES_W-1:0]        dnlMax,
  output logic [RES_W-1:0]        inlMax,
  output logic signed [RES_W-1:0] rdDnl,
  output logic signed [RES_W-1:0] rdInl
);
  localparam int NCODE = 1 << CODE_W;
  localparam int INNER = NCODE - 2;
  localparam int TOT_W = CNT_W + CODE_W;
  localparam int NUM_W = CNT_W + CODE_W + FRAC;
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic signed [RES_W-1:0] ONE = RES_W'(1 << FRAC);

  logic [CNT_W-1:0]        hist   [NCODE];
  logic signed [RES_W-1:0] dnlMem [NCODE];
  logic signed [RES_W-1:0] inlMem [NCODE];
  logic [TOT_W-1:0]        total;
  logic signed [RES_W-1:0] inlAcc;
  logic [NUM_W-1:0]        numer, quo;
  logic signed [RES_W-1:0] widthFx, dnlNew, inlNew;
  logic                    hitOk, atSat, isInner;

  function automatic logic [RES_W-1:0] magOf(input logic signed [RES_W-1:0] v);
    return (v < 0) ? RES_W'(-v) : RES_W'(v);
  endfunction

  assign hitOk   = ctl.capEn && codeValid;
  assign atSat   = (hist[code] == SAT);
  assign isInner = (code != '0) && (code != '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCODE; i++) hist[i] <= '0;
      total   <= '0;
      ovfFlag <= 1'b0;
    end else if (ctl.clrAll) begin
      for (int i = 0; i < NCODE; i++) hist[i] <= '0;
      total   <= '0;
      ovfFlag <= 1'b0;
    end else if (hitOk) begin
      if (atSat) begin
        ovfFlag <= 1'b1;
      end else begin
        hist[code] <= hist[code] + 1'b1;
        if (isInner) total <= total + 1'b1;
      end
    end
  end

  assign totalZero = (total == '0);
  assign numer     = (NUM_W'(hist[idx]) * NUM_W'(INNER)) << FRAC;

  adc_histo_div #(.NUM_W(NUM_W), .DEN_W(TOT_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .load  (ctl.divLoad),
    .num   (numer),
    .den   (total),
    .quo   (quo),
    .qDone (divDone)
  );

  // Width is bounded by INNER<<FRAC; clamp keeps the narrowing explicit.
  assign widthFx = (|quo[NUM_W-1:RES_W-1]) ? {1'b0, {(RES_W-1){1'b1}}}
                                           : {1'b0, quo[RES_W-2:0]};
  assign dnlNew  = widthFx - ONE;
  assign inlNew  = inlAcc + dnlNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCODE; i++) begin
        dnlMem[i] <= '0;
        inlMem[i] <= '0;
      end
      inlAcc  <= '0;
      dnlMax  <= '0;
      inlMax  <= '0;
      errFlag <= 1'b0;
    end else if (ctl.clrAll) begin
      for (int i = 0; i < NCODE; i++) begin
        dnlMem[i] <= '0;
        inlMem[i] <= '0;
      end
      inlAcc  <= '0;
      dnlMax  <= '0;
      inlMax  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.setErr) errFlag <= 1'b1;
      if (ctl.commit) begin
        dnlMem[idx] <= dnlNew;
        inlMem[idx] <= inlNew;
        inlAcc      <= inlNew;
        if (magOf(dnlNew) > dnlMax) dnlMax <= magOf(dnlNew);
        if (magOf(inlNew) > inlMax) inlMax <= magOf(inlNew);
      end
    end
  end

  assign rdDnl = dnlMem[rdAddr];
  assign rdInl = inlMem[rdAddr];
endmodule

// File: rtl/adc_histo_ctl.sv
module adc_histo_ctl
  import adc_histo_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic              totalZero,
  input  logic              divDone,
  output histoCtl_t         ctl,
  output logic [CODE_W-1:0] idx,
  output logic              done
);
  localparam logic [CODE_W-1:0] FIRST = CODE_W'(1);
  localparam logic [CODE_W-1:0] LAST  = CODE_W'((1 << CODE_W) - 2);

  typedef enum logic [2:0] {S_IDLE, S_CAPT, S_LOAD, S_WAIT, S_FIN} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= FIRST;
    end else if (start) begin
      state <= S_CAPT;
      idx   <= FIRST;
    end else begin
      unique case (state)
        S_CAPT: if (stop) state <= totalZero ? S_FIN : S_LOAD;
        S_LOAD: state <= S_WAIT;
        S_WAIT: if (divDone) begin
          if (idx == LAST) state <= S_FIN;
          else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end
        end
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clrAll  = start;
    ctl.capEn   = (state == S_CAPT) && !stop && !start;
    ctl.divLoad = (state == S_LOAD) && !start;
    ctl.commit  = (state == S_WAIT) && divDone && !start;
    ctl.setErr  = (state == S_CAPT) && stop && totalZero && !start;
    done        = (state == S_FIN);
  end
endmodule

// File: rtl/adc_histo_lin.sv
module adc_histo_lin
  import adc_histo_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16,
  parameter int FRAC   = 8,
  localparam int RES_W = CODE_W + FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    codeValid,
  input  logic [CODE_W-1:0]       code,
  input  logic [CODE_W-1:0]       rdAddr,
  output logic                    done,
  output logic                    errFlag,
  output logic                    ovfFlag,
  output logic [RES_W-1:0]        dnlMax,
  output logic [RES_W-1:0]        inlMax,
  output logic signed [RES_W-1:0] rdDnl,
  output logic signed [RES_W-1:0] rdInl
);
  histoCtl_t         ctl;
  logic [CODE_W-1:0] idx;
  logic              totalZero, divDone;

  adc_histo_ctl #(.CODE_W(CODE_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stop      (stop),
    .totalZero (totalZero),
    .divDone   (divDone),
    .ctl       (ctl),
    .idx       (idx),
    .done      (done)
  );

  adc_histo_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC(FRAC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .idx       (idx),
    .codeValid (codeValid),
    .code      (code),
    .rdAddr    (rdAddr),
    .totalZero (totalZero),
    .divDone   (divDone),
    .errFlag   (errFlag),
    .ovfFlag   (ovfFlag),
    .dnlMax    (dnlMax),
    .inlMax    (inlMax),
    .rdDnl     (rdDnl),
    .rdInl     (rdInl)
  );
endmodule

// File: rtl/adc_histo_chk.sv
module adc_histo_chk #(
  parameter int RES_W   = 16,
  parameter int MAG_LIM = 15872
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic             errFlag,
  input logic             ovfFlag,
  input logic [RES_W-1:0] dnlMax,
  input logic [RES_W-1:0] inlMax
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (dnlMax == '0 && inlMax == '0)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !start) |=> ovfFlag); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!errFlag && !ovfFlag && dnlMax == '0 && inlMax == '0)); // R2
  AST_INL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (inlMax <= RES_W'(MAG_LIM)) && (dnlMax <= RES_W'(MAG_LIM))); // R7
endmodule

bind adc_histo_lin adc_histo_chk #(
  .RES_W   (RES_W),
  .MAG_LIM (((1 << CODE_W) - 2) << FRAC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .done    (done),
  .errFlag (errFlag),
  .ovfFlag (ovfFlag),
  .dnlMax  (dnlMax),
  .inlMax  (inlMax)
);

// File: tb/adc_histo_lin_bench.sv
module adc_histo_lin_bench;
  localparam int CODE_W = 6;
  localparam int CNT_W  = 10;
  localparam int FRAC   = 8;
  localparam int RES_W  = CODE_W + FRAC + 2;
  localparam int NCODE  = 1 << CODE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, stop = 1'b0, codeValid = 1'b0;
  logic [CODE_W-1:0] code = '0, rdAddr = '0;
  logic done, errFlag, ovfFlag;
  logic [RES_W-1:0] dnlMax, inlMax;
  logic signed [RES_W-1:0] rdDnl, rdInl;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  adc_histo_lin #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC(FRAC)) u_adc_histo_lin (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .codeValid(codeValid),
    .code(code), .rdAddr(rdAddr), .done(done), .errFlag(errFlag), .ovfFlag(ovfFlag),
    .dnlMax(dnlMax), .inlMax(inlMax), .rdDnl(rdDnl), .rdInl(rdInl)
  );

  // j, hits at j, hits at j+1, exp dnlMax, exp inlMax, exp DNL(j), exp DNL(j+1), exp INL(j)
  typedef struct packed {
    int j; int hJ; int hJ1; int eDnlMax; int eInlMax; int eDnlJ; int eDnlJ1; int eInlJ;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{10, 4, 4,   0,   0,    0,    0,    0},
    '{20, 8, 0, 256, 256,  256, -256,  256},
    '{30, 6, 2, 128, 128,  128, -128,  128},
    '{ 1, 8, 0, 256, 256,  256, -256,  256},
    '{61, 2, 6, 128, 128, -128,  128, -128},
    '{40, 5, 4,  62,  78,   62,   -2,  -16}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCapture(input int j, input int hJ, input int hJ1,
                            input int base, input int endHits, input bit junk);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < NCODE; c++) begin
      int h;
      h = (c == 0 || c == NCODE - 1) ? endHits : (c == j) ? hJ : (c == j + 1) ? hJ1 : base;
      for (int k = 0; k < h; k++) begin
        codeValid = 1'b1;
        code = CODE_W'(c);
        @(negedge clk);
      end
    end
    codeValid = 1'b0;
    stop = 1'b1;
    code = CODE_W'(12);
    codeValid = 1'b1;          // sample in the stop cycle must be ignored (R1)
    @(negedge clk);
    stop = 1'b0;
    codeValid = 1'b0;
    if (junk) begin
      for (int k = 0; k < 20; k++) begin
        codeValid = 1'b1;
        code = CODE_W'(10);
        @(negedge clk);
      end
      codeValid = 1'b0;
    end
    begin
      int w;
      w = 0;
      while (!done && w < 10000) begin
        @(negedge clk);
        w++;
      end
      check("R8 done seen", int'(done), 1);
    end
  endtask

  task automatic readCode(input int a, output int d, output int i);
    rdAddr = CODE_W'(a);
    #1;
    d = int'(rdDnl);
    i = int'(rdInl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int d, i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R2)
    check("R2 reset done", int'(done), 0);
    check("R2 reset errFlag", int'(errFlag), 0);
    check("R2 reset ovfFlag", int'(ovfFlag), 0);
    check("R7 reset dnlMax", int'(dnlMax), 0);

    // table walk: R5 R6 R7 R4
    for (int v = 0; v < 6; v++) begin
      runCapture(VEC[v].j, VEC[v].hJ, VEC[v].hJ1, 4, 9, 1'b0);
      check("R7 dnlMax", int'(dnlMax), VEC[v].eDnlMax);
      check("R7 inlMax", int'(inlMax), VEC[v].eInlMax);
      check("R9 errFlag low", int'(errFlag), 0);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
      readCode(VEC[v].j, d, i);
      check("R5 DNL at j", d, VEC[v].eDnlJ);
      check("R6 INL at j", i, VEC[v].eInlJ);
      readCode(VEC[v].j + 1, d, i);
      check("R5 DNL at j+1", d, VEC[v].eDnlJ1);
      readCode(NCODE - 2, d, i);
      check("R6 INL last inner", i, (v == 5) ? -60 : 0);
      readCode(0, d, i);
      check("R4 end code 0 DNL", d, 0);
      readCode(NCODE - 1, d, i);
      check("R4 top end code INL", i, 0);
    end

    // R1: samples after stop (during analysis) ignored
    runCapture(200, 0, 0, 4, 9, 1'b1);
    check("R1 junk ignored dnlMax", int'(dnlMax), 0);
    readCode(10, d, i);
    check("R1 junk ignored DNL code10", d, 0);

    // R3 + R4: saturate end code 0, inner results unaffected
    runCapture(200, 0, 0, 4, 1030, 1'b0);
    check("R3 ovfFlag set", int'(ovfFlag), 1);
    check("R4 sat end code no effect", int'(dnlMax), 0);

    // R2: next start clears ovf; R9: empty inner histogram
    runCapture(200, 0, 0, 0, 5, 1'b0);
    check("R2 ovf cleared", int'(ovfFlag), 0);
    check("R9 errFlag", int'(errFlag), 1);
    check("R9 dnlMax zero", int'(dnlMax), 0);
    check("R9 inlMax zero", int'(inlMax), 0);
    readCode(20, d, i);
    check("R9 per-code zero", d, 0);
    @(negedge clk);
    check("R9 done single", int'(done), 0);

    // R2: start clears error
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 err cleared", int'(errFlag), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule